// File: doc/BRIEF.md
# Multi-CPU Interrupt Routing Controller

This block gathers level-sensitive interrupt lines from peripherals and delivers them to up to four processors, one interrupt output per processor. Each source carries one global enable bit and a routing field that names the processors allowed to take it. Each processor also holds its own mask bit for every source. A processor reaches the controller through a simple register port. It tags each access with its own number on `cpu_sel`. Enable and mask state change when the processor writes a source number to a set or clear register, so no read-modify-write is ever needed.

Three sources are private to each processor: sources 0 and 1 (summaries from a separate doorbell block) and source 5 (a local timer). Each processor has its own copy of these three lines, and only that processor's mask gates them. A processor reads its acknowledge register to learn which source to service. The read returns the lowest-numbered source that qualifies for that processor, or the all-ones code when none does. Reading does not clear anything, because a source stays pending for as long as its line is high.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every global enable is 0, every per-processor mask bit is 1 (masked) and every routing field is 0. Every `irq_out` bit is 0, and an acknowledge read returns 0x3FF.
- R2: Writing a value below NUM_SRC to offset 0x030 sets that source's global enable. Writing it to offset 0x034 clears that enable.
- R3: Writing a value below NUM_SRC to offset 0x048 masks that source for the processor named by `cpu_sel`, and writing it to offset 0x04C unmasks it. The mask bits of the other processors do not change.
- R4: Offset 0x100 + 4*i is the routing register of source i. Bit c of bits [NUM_CPUS-1:0] allows delivery to processor c. The register reads back what was written, with its other bits read as 0.
- R5: A read of offset 0x000 returns NUM_SRC in bits [11:2], with all other bits 0. Writes to 0x000 have no effect.
- R6: A read of offset 0x044 returns, in bits [9:0], the lowest-numbered source that qualifies for the processor on `cpu_sel`. It returns 0x3FF when no source qualifies. Bits [31:10] read as 0.
- R7: Sources are level-sensitive. An acknowledge read does not clear a source, and the source stops qualifying once its line goes low.
- R8: Sources 0, 1 and 5 are private. For processor c they come from `local_lines` bits c*3+0, c*3+1 and c*3+2, and only that processor's mask gates them. The shared `src_lines` bits, the global enable and the routing field of these sources have no effect on delivery.
- R9: A shared source qualifies for processor c when its line is high, its global enable is 1, routing bit c is 1 and processor c's mask bit is 0. `irq_out[c]` is the OR of all sources that qualify for c, registered, so it follows the inputs one clock later.
- R10: A set or clear write whose value is NUM_SRC or more changes no state. Register data is returned one clock after `rd_en`, and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lines | input | NUM_SRC | Shared level interrupt lines, one per source |
| local_lines | input | NUM_CPUS*3 | Private lines: bit c*3+k feeds processor c's source 0, 1 or 5 for k = 0, 1, 2 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| cpu_sel | input | 2 | Number of the processor making the access |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the clock after `rd_en` |
| irq_out | output | NUM_CPUS | Interrupt request to each processor |

## Verification
The delivery path is first driven through directed patterns, each of which isolates one gate. A single shared source is opened stage by stage through enable, routing and mask, so that a missing term shows up as an early interrupt. Two shared sources are then raised together to confirm that the lower number wins, and the lower one is then dropped to confirm the level rule rather than a latched one. Private-line patterns raise the shared copy of source 5 on its own and then the private copy, which separates the private path from the shared path. A set-enable write with an out-of-range value that aliases a live source after truncation exposes a missing range check. A long seeded random mix of set, clear, routing and line changes then compares every processor's output and acknowledge value against a bench model after each step.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int ID_W      = 10;
    localparam int MAX_CPUS  = 4;
    localparam int SEL_W     = 2;
    localparam int LOCAL_CNT = 3;

    localparam logic [ID_W-1:0] ID_NONE = '1;

    // Register offsets (byte addresses)
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_EN_SET  = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR  = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_ACK     = 12'h044;
    localparam logic [ADDR_W-1:0] OFS_MSK_SET = 12'h048;
    localparam logic [ADDR_W-1:0] OFS_MSK_CLR = 12'h04C;
    localparam logic [ADDR_W-1:0] OFS_ROUTE   = 12'h100;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_EN_SET,
        CMD_EN_CLR,
        CMD_MSK_SET,
        CMD_MSK_CLR,
        CMD_ROUTE
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e             kind;
        logic [ID_W-1:0]       idx;
        logic [MAX_CPUS-1:0]   route;
    } reg_cmd_t;

    // Slot of a private (per-processor) source in the local line group, -1 if shared
    function automatic int local_slot(input int src);
        case (src)
            0:       return 0;
            1:       return 1;
            5:       return 2;
            default: return -1;
        endcase
    endfunction

    function automatic bit is_local(input int src);
        return local_slot(src) >= 0;
    endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_CPUS = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output reg_cmd_t          cmd,
    output logic              route_hit,
    output logic [ID_W-1:0]   route_idx
);

    logic [ADDR_W-1:0] route_off;
    logic              idx_ok;

    always_comb begin
        route_off = addr - OFS_ROUTE;
        route_idx = route_off[ADDR_W-1:2];
        route_hit = (addr >= OFS_ROUTE) && (addr[1:0] == 2'b00) &&
                    (route_idx < ID_W'(NUM_SRC));
        idx_ok    = wdata < DATA_W'(NUM_SRC);
    end

    always_comb begin
        cmd = '0;
        if (wr_en) begin
            cmd.idx = wdata[ID_W-1:0];
            unique case (addr)
                OFS_EN_SET:  if (idx_ok) cmd.kind = CMD_EN_SET;
                OFS_EN_CLR:  if (idx_ok) cmd.kind = CMD_EN_CLR;
                OFS_MSK_SET: if (idx_ok) cmd.kind = CMD_MSK_SET;
                OFS_MSK_CLR: if (idx_ok) cmd.kind = CMD_MSK_CLR;
                default: begin
                    if (route_hit) begin
                        cmd.kind  = CMD_ROUTE;
                        cmd.idx   = route_idx;
                        cmd.route = '0;
                        cmd.route[NUM_CPUS-1:0] = wdata[NUM_CPUS-1:0];
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/irq_route_src_bank.sv
module irq_route_src_bank
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_CPUS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  reg_cmd_t            cmd,
    output logic [NUM_SRC-1:0]  en_q,
    output logic [NUM_CPUS-1:0] route_q [NUM_SRC]
);

    logic unused_route_hi;
    assign unused_route_hi = ^cmd.route;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            for (int s = 0; s < NUM_SRC; s++) route_q[s] <= '0;
        end else begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (cmd.idx == ID_W'(s)) begin
                    case (cmd.kind)
                        CMD_EN_SET: en_q[s]    <= 1'b1;
                        CMD_EN_CLR: en_q[s]    <= 1'b0;
                        CMD_ROUTE:  route_q[s] <= cmd.route[NUM_CPUS-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/irq_route_cpu_lane.sv
module irq_route_cpu_lane
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  cmd_kind_e            cmd_kind,
    input  logic [ID_W-1:0]      cmd_idx,
    input  logic                 sel_me,
    input  logic [NUM_SRC-1:0]   src_lines,
    input  logic [LOCAL_CNT-1:0] local_lines,
    input  logic [NUM_SRC-1:0]   en,
    input  logic [NUM_SRC-1:0]   route_col,
    output logic [NUM_SRC-1:0]   mask_q,
    output logic                 irq_q,
    output logic [ID_W-1:0]      ack_id
);

    logic [NUM_SRC-1:0] qual;
    logic [NUM_SRC-1:0] sink;
    logic               lane_unused;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (sel_me) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (cmd_idx == ID_W'(s)) begin
                    if (cmd_kind == CMD_MSK_SET)      mask_q[s] <= 1'b1;
                    else if (cmd_kind == CMD_MSK_CLR) mask_q[s] <= 1'b0;
                end
            end
        end
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_qual
        if (is_local(s)) begin : g_private
            localparam int SLOT = local_slot(s);
            assign qual[s] = local_lines[SLOT] & ~mask_q[s];
            assign sink[s] = src_lines[s] ^ en[s] ^ route_col[s];
        end else begin : g_shared
            assign qual[s] = src_lines[s] & en[s] & route_col[s] & ~mask_q[s];
            assign sink[s] = 1'b0;
        end
    end

    assign lane_unused = ^sink;

    // Lowest-numbered qualifying source wins
    always_comb begin
        ack_id = ID_NONE;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (qual[s]) ack_id = ID_W'(s);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |qual;
    end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_CPUS = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SRC-1:0]            src_lines,
    input  logic [NUM_CPUS*LOCAL_CNT-1:0] local_lines,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [SEL_W-1:0]              cpu_sel,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic [NUM_CPUS-1:0]           irq_out
);

    reg_cmd_t                cmd;
    logic                    route_hit;
    logic [ID_W-1:0]         route_idx;
    logic [NUM_SRC-1:0]      en_q;
    logic [NUM_CPUS-1:0]     route_q [NUM_SRC];
    logic [NUM_SRC-1:0]      route_col [NUM_CPUS];
    logic [NUM_SRC*NUM_CPUS-1:0] mask_flat;
    logic [ID_W-1:0]         ack_ids [NUM_CPUS];
    logic [DATA_W-1:0]       read_val;

    irq_route_decode #(.NUM_SRC(NUM_SRC), .NUM_CPUS(NUM_CPUS)) u_decode (
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .cmd       (cmd),
        .route_hit (route_hit),
        .route_idx (route_idx)
    );

    irq_route_src_bank #(.NUM_SRC(NUM_SRC), .NUM_CPUS(NUM_CPUS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .en_q    (en_q),
        .route_q (route_q)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_lane
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_col
            assign route_col[c][s] = route_q[s][c];
        end

        irq_route_cpu_lane #(.NUM_SRC(NUM_SRC)) u_lane (
            .clk         (clk),
            .rst         (rst),
            .cmd_kind    (cmd.kind),
            .cmd_idx     (cmd.idx),
            .sel_me      (cpu_sel == SEL_W'(c)),
            .src_lines   (src_lines),
            .local_lines (local_lines[c*LOCAL_CNT +: LOCAL_CNT]),
            .en          (en_q),
            .route_col   (route_col[c]),
            .mask_q      (mask_flat[c*NUM_SRC +: NUM_SRC]),
            .irq_q       (irq_out[c]),
            .ack_id      (ack_ids[c])
        );
    end

    always_comb begin
        read_val = '0;
        if (addr == OFS_CTRL) begin
            read_val[11:2] = 10'(NUM_SRC);
        end else if (addr == OFS_ACK) begin
            read_val[ID_W-1:0] = ID_NONE;
            for (int c = 0; c < NUM_CPUS; c++) begin
                if (cpu_sel == SEL_W'(c)) read_val[ID_W-1:0] = ack_ids[c];
            end
        end else if (route_hit) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (route_idx == ID_W'(s)) read_val[NUM_CPUS-1:0] = route_q[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= read_val;
    end

endmodule

// File: rtl/irq_route_checks.sv
module irq_route_checks
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_CPUS = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          wr_en,
    input logic                          rd_en,
    input logic [SEL_W-1:0]              cpu_sel,
    input logic [ADDR_W-1:0]             addr,
    input logic [DATA_W-1:0]             wdata,
    input logic [DATA_W-1:0]             rdata,
    input logic [NUM_CPUS-1:0]           irq_out,
    input logic [NUM_SRC-1:0]            en_q,
    input logic [NUM_SRC*NUM_CPUS-1:0]   mask_flat
);

    logic            ack_rd_q, en_set_q, en_clr_q, msk_set_q, msk_clr_q;
    logic [SEL_W-1:0] sel_q;
    logic [ID_W-1:0]  idx_q;
    logic             idx_ok;

    assign idx_ok = wdata < DATA_W'(NUM_SRC);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_rd_q  <= 1'b0;
            en_set_q  <= 1'b0;
            en_clr_q  <= 1'b0;
            msk_set_q <= 1'b0;
            msk_clr_q <= 1'b0;
            sel_q     <= '0;
            idx_q     <= '0;
        end else begin
            ack_rd_q  <= rd_en && addr == OFS_ACK;
            en_set_q  <= wr_en && addr == OFS_EN_SET  && idx_ok;
            en_clr_q  <= wr_en && addr == OFS_EN_CLR  && idx_ok;
            msk_set_q <= wr_en && addr == OFS_MSK_SET && idx_ok;
            msk_clr_q <= wr_en && addr == OFS_MSK_CLR && idx_ok;
            sel_q     <= cpu_sel;
            idx_q     <= wdata[ID_W-1:0];
        end
    end

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> irq_out == '0);

    p_en_set_r2: assert property (@(posedge clk) disable iff (rst)
        en_set_q |-> en_q[idx_q]);

    p_en_clr_r2: assert property (@(posedge clk) disable iff (rst)
        en_clr_q |-> !en_q[idx_q]);

    p_mask_set_r3: assert property (@(posedge clk) disable iff (rst)
        msk_set_q |-> mask_flat[int'(sel_q)*NUM_SRC + int'(idx_q)]);

    p_mask_clr_r3: assert property (@(posedge clk) disable iff (rst)
        msk_clr_q |-> !mask_flat[int'(sel_q)*NUM_SRC + int'(idx_q)]);

    p_ack_range_r6: assert property (@(posedge clk) disable iff (rst)
        ack_rd_q |-> (rdata[DATA_W-1:ID_W] == '0) &&
                     (rdata[ID_W-1:0] == ID_NONE || rdata[ID_W-1:0] < ID_W'(NUM_SRC)));

    p_ack_matches_irq_r9: assert property (@(posedge clk) disable iff (rst)
        ack_rd_q |-> ((rdata[ID_W-1:0] == ID_NONE) == !irq_out[sel_q]));

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_quiet
        p_all_masked_quiet_r3: assert property (@(posedge clk) disable iff (rst)
            (&mask_flat[c*NUM_SRC +: NUM_SRC]) |=> !irq_out[c]);
    end

endmodule

bind irq_route_ctrl irq_route_checks #(.NUM_SRC(NUM_SRC), .NUM_CPUS(NUM_CPUS)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .cpu_sel   (cpu_sel),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .irq_out   (irq_out),
    .en_q      (en_q),
    .mask_flat (mask_flat)
);

// File: tb/test_irq_route_ctrl.sv
module test_irq_route_ctrl;

    localparam int NS = 32;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_lines = '0;
    logic [NC*3-1:0] local_lines = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [1:0]    cpu_sel = '0;
    logic [11:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NC-1:0] irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    bit     m_en   [NS];
    bit     m_mask [NC][NS];
    bit [3:0] m_route [NS];

    always #5 clk = ~clk;

    irq_route_ctrl #(.NUM_SRC(NS), .NUM_CPUS(NC)) i_irq_route_ctrl (
        .clk(clk), .rst(rst), .src_lines(src_lines), .local_lines(local_lines),
        .wr_en(wr_en), .rd_en(rd_en), .cpu_sel(cpu_sel), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    function automatic int slot_of(int s);
        if (s == 0) return 0;
        if (s == 1) return 1;
        if (s == 5) return 2;
        return -1;
    endfunction

    function automatic bit qual(int c, int s);
        int k = slot_of(s);
        if (k >= 0) return local_lines[c*3+k] && !m_mask[c][s];
        return src_lines[s] && m_en[s] && m_route[s][c] && !m_mask[c][s];
    endfunction

    function automatic int exp_ack(int c);
        for (int s = 0; s < NS; s++) if (qual(c, s)) return s;
        return 32'h3FF;
    endfunction

    function automatic bit exp_irq(int c);
        return exp_ack(c) != 32'h3FF;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            m_en[s] = 0;
            m_route[s] = '0;
            for (int c = 0; c < NC; c++) m_mask[c][s] = 1;
        end
    endtask

    task automatic model_write(int c, int a, int d);
        if (a == 'h30 && d < NS) m_en[d] = 1;
        else if (a == 'h34 && d < NS) m_en[d] = 0;
        else if (a == 'h48 && d < NS) m_mask[c][d] = 1;
        else if (a == 'h4C && d < NS) m_mask[c][d] = 0;
        else if (a >= 'h100 && a < 'h100 + 4*NS && a % 4 == 0) m_route[(a-'h100)/4] = d[3:0];
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(int c, int a, int d);
        cpu_sel = 2'(c); addr = 12'(a); wdata = 32'(d); wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        model_write(c, a, d);
    endtask

    task automatic rd(int c, int a, output logic [31:0] v);
        cpu_sel = 2'(c); addr = 12'(a); rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    // settle one cycle, then compare every output and acknowledge value
    task automatic check_all(string req);
        logic [31:0] v;
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NC; c++)
            chk(irq_out[c] == exp_irq(c), req, $sformatf("irq_out[%0d]", c), irq_out[c], exp_irq(c));
        for (int c = 0; c < NC; c++) begin
            rd(c, 'h44, v);
            chk(v == 32'(exp_ack(c)), req, $sformatf("ack cpu%0d", c), v, exp_ack(c));
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd7193));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, everything quiet even with lines high
        src_lines = '1;
        local_lines = '1;
        check_all("R1");

        // R5: control register, writes ignored
        rd(0, 'h000, v);
        chk(v == 32'(NS << 2), "R5", "control", v, NS << 2);
        wr(1, 'h000, 32'hFFFF_FFFF);
        rd(1, 'h000, v);
        chk(v == 32'(NS << 2), "R5", "control after write", v, NS << 2);

        src_lines = '0;
        local_lines = '0;

        // R9: one shared source opened stage by stage
        src_lines[7] = 1'b1;
        wr(2, 'h30, 7);
        check_all("R9");
        wr(0, 'h100 + 4*7, 4'b0100);
        check_all("R9");
        wr(2, 'h4C, 7);
        check_all("R9");
        chk(irq_out == 4'b0100, "R9", "only cpu2 raised", irq_out, 4'b0100);

        // R3/R4: unmask on cpu0 does not deliver when not routed
        wr(0, 'h4C, 7);
        check_all("R4");
        chk(irq_out[0] == 1'b0, "R4", "cpu0 not routed", irq_out[0], 0);
        rd(3, 'h100 + 4*7, v);
        chk(v == 32'h4, "R4", "route readback", v, 4);
        wr(2, 'h48, 7);
        check_all("R3");
        chk(irq_out[2] == 1'b0, "R3", "cpu2 masked", irq_out[2], 0);
        wr(2, 'h4C, 7);

        // R6: lowest number wins
        src_lines[3] = 1'b1;
        wr(1, 'h30, 3);
        wr(1, 'h100 + 4*3, 4'b0110);
        wr(2, 'h4C, 3);
        check_all("R6");
        rd(2, 'h44, v);
        chk(v == 32'd3, "R6", "lowest id", v, 3);

        // R7: reading does not clear; dropping the line does
        rd(2, 'h44, v);
        chk(v == 32'd3, "R7", "second read", v, 3);
        src_lines[3] = 1'b0;
        check_all("R7");
        rd(2, 'h44, v);
        chk(v == 32'd7, "R7", "after line drop", v, 7);

        // R2: clear enable removes the source
        wr(3, 'h34, 7);
        check_all("R2");
        chk(irq_out[2] == 1'b0, "R2", "disabled", irq_out[2], 0);

        // R10: out-of-range value aliasing source 7 changes nothing
        wr(2, 'h30, 7 + NS);
        check_all("R10");
        chk(irq_out[2] == 1'b0, "R10", "alias ignored", irq_out[2], 0);
        rd(2, 'h020, v);
        chk(v == 32'd0, "R10", "unmapped read", v, 0);

        // R8: shared copy of source 5 does nothing; private copy does
        src_lines[5] = 1'b1;
        wr(0, 'h30, 5);
        wr(0, 'h100 + 4*5, 4'b1111);
        for (int c = 0; c < NC; c++) wr(c, 'h4C, 5);
        check_all("R8");
        chk(irq_out == 4'b0000, "R8", "shared copy ignored", irq_out, 0);
        local_lines[1*3+2] = 1'b1;
        wr(0, 'h34, 5);
        wr(0, 'h100 + 4*5, 4'b0000);
        check_all("R8");
        rd(1, 'h44, v);
        chk(v == 32'd5, "R8", "private timer", v, 5);
        local_lines[2*3+0] = 1'b1;
        wr(2, 'h4C, 0);
        check_all("R8");

        // random phase
        for (int it = 0; it < 400; it++) begin
            int op = $urandom % 7;
            int c  = $urandom % NC;
            int ix = $urandom % (NS + 8);
            case (op)
                0: wr(c, 'h30, ix);
                1: wr(c, 'h34, ix);
                2: wr(c, 'h48, ix);
                3, 4: wr(c, 'h4C, ix);
                5: wr(c, 'h100 + 4*($urandom % NS), $urandom % 16);
                default: begin
                    src_lines = $urandom;
                    local_lines = 12'($urandom);
                end
            endcase
            check_all("R9");
        end

        done = 1;
        finish_run();
    end

endmodule